// File: doc/BRIEF.md
# Iterative 320-bit Sponge Permutation Round Engine

The block computes a 320-bit keyless permutation of the kind used inside a lightweight authenticated cipher. The state is five 64-bit lanes. On every clock cycle while running, the engine performs one complete round on its state register. A round has three parts, applied in this order: an 8-bit round constant is mixed into the state, a bitsliced 5-bit nonlinear substitution is applied at each of the 64 bit positions, and a linear rotate-and-XOR diffusion is applied to each lane.

A surrounding mode controller loads a state through a valid/ready input handshake. The same handshake supplies a 4-bit starting-round index. The engine then runs the tail of the 12-round schedule that begins at that index. The handshake has back-pressure: `start_ready` is high only while the engine is idle. A `start_valid` that is seen while the engine is busy is not accepted, and it has no effect. The output side has no back-pressure. `done` pulses for one cycle when the last round's result is registered. After that, `state_out` holds that result until the next accepted load, so the consumer may read it at any later time.

Top module: `perm_round_core`

## Requirements
- R1: Lane n (n = 0..4) occupies bits [64n+63:64n] of both `state_in` and `state_out`, and its least significant byte is in bits [64n+7:64n].
- R2: Each round starts by XORing the 8-bit round constant into bits [7:0] of lane 2. No other bit is touched by this step.
- R3: The substitution works on the lanes x0..x4 as a unit, in this order. First x0^=x4, x4^=x3 and x2^=x1. Then every t_i=(~x_i)&x_((i+1) mod 5) is formed from those values, and only after that is each x_i^=t_((i+1) mod 5) applied. Finally x1^=x0, x0^=x4, x3^=x2 and x2=~x2.
- R4: The diffusion replaces every lane x with x ^ (x ror a) ^ (x ror b), where ror is a right rotation. The pair (a,b) is (19,28) for lane 0, (61,39) for lane 1, (1,6) for lane 2, (10,17) for lane 3 and (7,41) for lane 4.
- R5: A run whose starting index is f (0..11) uses 0xF0-15*f as its first constant and lowers the constant by 0x0F after every round. The run ends after the round that used 0x4B, so it performs 12-f rounds.
- R6: A starting index above 11 is handled as 11. Such a run therefore performs exactly one round, with constant 0x4B.
- R7: The engine completes one full round per clock cycle. `done` is high for exactly one cycle, and that cycle is the (12-f)th cycle after the clock edge that accepted the load. `busy` is high from that acceptance until the same edge that raises `done`.
- R8: While the engine is idle, `state_out` does not change until a new load is accepted.
- R9: `start_ready` is low while `busy` is high. A `start_valid` in that time is ignored: neither the running state nor its round count is affected.
- R10: A synchronous active-high `rst` clears `busy`, `done` and the whole state register to zero at the next clock edge, and this also applies in the middle of a run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Load request carrying `state_in` and `first_round` |
| start_ready | output | 1 | High when a load request will be accepted (engine idle) |
| first_round | input | 4 | Starting index in the 12-round schedule; values above 11 act as 11 |
| state_in | input | 320 | State to permute, five 64-bit lanes |
| busy | output | 1 | Rounds are in progress |
| done | output | 1 | One-cycle pulse when the final round result is registered |
| state_out | output | 320 | Current state register; holds the result while idle |

## Verification
The case that is hardest to reach from the ports is a load request that arrives during a run. The request must leave both the running state and the run's remaining round count unchanged. The bench raises `start_valid` with an unrelated state and index in the middle of a run. It then checks that `start_ready` is low at that time, that the run still ends on its original cycle, and that the result matches the reference model of the original load. Short tails need the starting index to reach the clamp region. For that, the vector table includes indices 11 and 15, both of which must give a single round with the final constant.

// File: rtl/perm_pkg.sv
package perm_pkg;
  localparam int unsigned LANES    = 5;
  localparam int unsigned LANE_W   = 64;
  localparam int unsigned STATE_W  = LANES * LANE_W;
  localparam int unsigned RC_W     = 8;
  localparam int unsigned FIRST_W  = 4;
  localparam int unsigned LAST_IDX = 11;
  localparam logic [RC_W-1:0] RC_BASE = 8'hF0;
  localparam logic [RC_W-1:0] RC_STEP = 8'h0F;
  localparam logic [RC_W-1:0] RC_STOP = 8'h3C;

  typedef logic [LANE_W-1:0] lane_t;
  typedef lane_t [LANES-1:0] state_t;

  // rotation pairs per lane for the linear layer
  function automatic int unsigned rot_lo(input int unsigned lane);
    case (lane)
      0: rot_lo = 19;
      1: rot_lo = 61;
      2: rot_lo = 1;
      3: rot_lo = 10;
      default: rot_lo = 7;
    endcase
  endfunction

  function automatic int unsigned rot_hi(input int unsigned lane);
    case (lane)
      0: rot_hi = 28;
      1: rot_hi = 39;
      2: rot_hi = 6;
      3: rot_hi = 17;
      default: rot_hi = 41;
    endcase
  endfunction
endpackage

// File: rtl/perm_const_sched.sv
module perm_const_sched
  import perm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FIRST_W-1:0] first,
  input  logic               step,
  output logic [RC_W-1:0]    rc,
  output logic               last
);
  logic [RC_W-1:0]    rc_q;
  logic [FIRST_W-1:0] first_cl;
  logic [RC_W-1:0]    rc_init;
  logic [RC_W-1:0]    rc_next;

  always_comb begin
    first_cl = (first > FIRST_W'(LAST_IDX)) ? FIRST_W'(LAST_IDX) : first;
    // base minus 15*f: (f<<4) - f
    rc_init  = RC_BASE - ((RC_W'(first_cl) << 4) - RC_W'(first_cl));
    rc_next  = rc_q - RC_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst)       rc_q <= '0;
    else if (load) rc_q <= rc_init;
    else if (step) rc_q <= rc_next;
  end

  assign rc   = rc_q;
  assign last = (rc_next == RC_STOP);
endmodule

// File: rtl/perm_sbox_layer.sv
module perm_sbox_layer
  import perm_pkg::*;
(
  input  state_t s_in,
  output state_t s_out
);
  state_t pre;
  state_t tmp;
  state_t mix;

  always_comb begin
    pre    = s_in;
    pre[0] = s_in[0] ^ s_in[4];
    pre[4] = s_in[4] ^ s_in[3];
    pre[2] = s_in[2] ^ s_in[1];
  end

  // all chi terms come from the pre-mixed lanes
  for (genvar i = 0; i < LANES; i++) begin : g_chi
    localparam int unsigned NX = (i + 1) % LANES;
    assign tmp[i] = (~pre[i]) & pre[NX];
    assign mix[i] = pre[i] ^ tmp[NX];
  end

  always_comb begin
    s_out    = mix;
    s_out[1] = mix[1] ^ mix[0];
    s_out[0] = mix[0] ^ mix[4];
    s_out[3] = mix[3] ^ mix[2];
    s_out[2] = ~mix[2];
  end
endmodule

// File: rtl/perm_diffuse_layer.sv
module perm_diffuse_layer
  import perm_pkg::*;
(
  input  state_t s_in,
  output state_t s_out
);
  function automatic lane_t ror(input lane_t x, input int unsigned sh);
    ror = (x >> sh) | (x << (LANE_W - sh));
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned RA = rot_lo(i);
    localparam int unsigned RB = rot_hi(i);
    assign s_out[i] = s_in[i] ^ ror(s_in[i], RA) ^ ror(s_in[i], RB);
  end
endmodule

// File: rtl/perm_round_core.sv
module perm_round_core
  import perm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               start_valid,
  output logic               start_ready,
  input  logic [FIRST_W-1:0] first_round,
  input  logic [STATE_W-1:0] state_in,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] state_out
);
  logic      busy_q, done_q, accept, last;
  logic [RC_W-1:0] rc;
  state_t    st_q, after_rc, after_sub, after_dif;

  assign accept = start_valid && !busy_q;

  perm_const_sched u_sched (
    .clk(clk), .rst(rst), .load(accept), .first(first_round),
    .step(busy_q), .rc(rc), .last(last)
  );

  always_comb begin
    after_rc          = st_q;
    after_rc[2][7:0]  = st_q[2][7:0] ^ rc;
  end

  perm_sbox_layer    u_sbox (.s_in(after_rc),  .s_out(after_sub));
  perm_diffuse_layer u_diff (.s_in(after_sub), .s_out(after_dif));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      st_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        st_q   <= state_t'(state_in);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        st_q <= after_dif;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign start_ready = !busy_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign state_out   = STATE_W'(st_q);
endmodule

// File: rtl/perm_round_core_chk.sv
module perm_round_core_chk
  import perm_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               start_valid,
  input logic               start_ready,
  input logic [FIRST_W-1:0] first_round,
  input logic               busy,
  input logic               done,
  input logic [STATE_W-1:0] state_out
);
  localparam int unsigned CNT_W = 5;
  logic [CNT_W-1:0] cnt_q, exp_q;
  logic acc;

  assign acc = start_valid && start_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      exp_q <= '0;
    end else if (acc) begin
      cnt_q <= '0;
      exp_q <= (first_round > FIRST_W'(LAST_IDX)) ? CNT_W'(1)
                                                  : CNT_W'(12 - first_round);
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!busy && !done && state_out == '0));
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    acc |=> busy);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_valid) |=> $stable(state_out));
  p_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start_valid) |-> !start_ready);
  p_count_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt_q == exp_q));
endmodule

bind perm_round_core perm_round_core_chk chk_i (
  .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
  .first_round(first_round), .busy(busy), .done(done), .state_out(state_out)
);

// File: tb/perm_round_core_tb_top.sv
module perm_round_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 320;

  // {first index, expected round count}
  localparam logic [11:0] VEC [8] = '{
    {4'd0, 8'd12}, {4'd6, 8'd6}, {4'd11, 8'd1}, {4'd15, 8'd1},
    {4'd3, 8'd9},  {4'd9, 8'd3}, {4'd12, 8'd1}, {4'd0, 8'd12}
  };

  logic clk = 0, rst = 1, start_valid = 0;
  logic [3:0] first_round = '0;
  logic [SW-1:0] state_in = '0;
  logic start_ready, busy, done;
  logic [SW-1:0] state_out;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  perm_round_core dut_i (
    .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
    .first_round(first_round), .state_in(state_in), .busy(busy), .done(done),
    .state_out(state_out)
  );

  function automatic logic [63:0] rr(input logic [63:0] x, input int s);
    logic [127:0] d;
    d = {x, x} >> s;
    return d[63:0];
  endfunction

  function automatic logic [SW-1:0] model(input logic [SW-1:0] s, input int first);
    logic [63:0] x[5];
    logic [63:0] t[5];
    logic [7:0] c;
    int f;
    int ra[5] = '{19, 61, 1, 10, 7};
    int rb[5] = '{28, 39, 6, 17, 41};
    for (int i = 0; i < 5; i++) x[i] = s[64*i +: 64];
    f = (first > 11) ? 11 : first;
    c = 8'(240 - 15 * f);
    forever begin
      x[2][7:0] = x[2][7:0] ^ c;
      x[0] = x[0] ^ x[4]; x[4] = x[4] ^ x[3]; x[2] = x[2] ^ x[1];
      for (int i = 0; i < 5; i++) t[i] = ~x[i] & x[(i + 1) % 5];
      for (int i = 0; i < 5; i++) x[i] = x[i] ^ t[(i + 1) % 5];
      x[1] = x[1] ^ x[0]; x[0] = x[0] ^ x[4]; x[3] = x[3] ^ x[2]; x[2] = ~x[2];
      for (int i = 0; i < 5; i++) x[i] = x[i] ^ rr(x[i], ra[i]) ^ rr(x[i], rb[i]);
      c = c - 8'h0F;
      if (c == 8'h3C) break;
    end
    for (int i = 0; i < 5; i++) model[64*i +: 64] = x[i];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [SW-1:0] act,
                     input logic [SW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] rnd_state();
    logic [SW-1:0] v;
    for (int i = 0; i < 10; i++) v[32*i +: 32] = $urandom;
    return v;
  endfunction

  // load, optionally inject a busy-time request, wait for done
  task automatic run(input logic [3:0] f, input logic [SW-1:0] s, input bit inject,
                     output int cyc);
    @(negedge clk);
    start_valid = 1; first_round = f; state_in = s;
    @(negedge clk);
    start_valid = 0;
    cyc = 0;
    while (cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (done) break;
      if (inject && cyc == 2) begin
        chk(!start_ready, "R9 ready low while busy", SW'(start_ready), '0);
        start_valid = 1; first_round = 4'd11; state_in = ~s;
      end
      if (inject && cyc == 3) start_valid = 0;
    end
    start_valid = 0;
    if (cyc >= 100) chk(0, "R7 watchdog no done", '0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cyc, f, n;
    logic [SW-1:0] s, e, held;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !done && start_ready && state_out == '0, "R10 reset state",
        state_out, '0);

    for (int k = 0; k < 8; k++) begin
      f = int'(VEC[k][11:8]);
      n = int'(VEC[k][7:0]);
      s = rnd_state();
      e = model(s, f);
      run(VEC[k][11:8], s, 1'b0, cyc);
      chk(cyc == n, "R5 R6 R7 round count", SW'(cyc), SW'(n));
      chk(state_out == e, "R1 R2 R3 R4 result vs model", state_out, e);
      chk(!busy, "R7 busy low with done", SW'(busy), '0);
      held = state_out;
      @(negedge clk);
      chk(!done, "R7 done single cycle", SW'(done), '0);
      repeat (3) @(negedge clk);
      chk(state_out == held, "R8 output held while idle", state_out, held);
    end

    // R2 with zero state and one round: constant lands only in lane 2 low byte
    e = model('0, 11);
    run(4'd11, '0, 1'b0, cyc);
    chk(state_out == e, "R2 zero state single round", state_out, e);

    // R9: request while busy is ignored
    s = rnd_state();
    e = model(s, 6);
    run(4'd6, s, 1'b1, cyc);
    chk(cyc == 6, "R9 round count unchanged", SW'(cyc), SW'(6));
    chk(state_out == e, "R9 result unaffected", state_out, e);

    // R10: reset mid-run
    @(negedge clk);
    start_valid = 1; first_round = 0; state_in = rnd_state();
    @(negedge clk);
    start_valid = 0;
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(!busy && !done && state_out == '0, "R10 reset mid-run", state_out, '0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule